// File: doc/BRIEF.md
# Phase-Synchronised Voice Mask Release

This block releases voices from a 64-entry per-voice stop mask without disturbing the engine that services those voices. The mask lives in two 32-bit banks: the low bank covers voices 0 to 31 and the high bank voices 32 to 63. A running channel counter, produced outside the block, tells which part of the sample cycle the voice engine is working on. Each bank is rewritten only while the engine is busy with the other half of the cycle, so the two writes never collide with service of the voices they touch.

A caller pulses the start input with a 64-bit vector of voices to release. The block waits for the third quarter of the channel counter and clears the selected low-bank bits, then waits for the first quarter of the following cycle and clears the selected high-bank bits. A sample counter, also from outside, is checked at the high-bank write: if exactly one sample cycle boundary passed since the low-bank write, the result is ok, otherwise the caller is told to retry. If the counter never reaches the needed phase within a bounded number of polls, the sequence gives up with a timeout and the high bank is left alone.

Top module: `vmr_release`

## Requirements
- R1: After reset both mask banks hold the parameter RESET_MASK (default all ones), busy is low and the result code is 2'b00 (none).
- R2: A start pulse while idle captures the clear vector; busy is high from the next cycle and the result code reads 2'b00 while busy.
- R3: The low bank changes only in the cycle after a poll in which the channel counter's top two bits read 2'b10 (third quarter); its new value is the old low bank ANDed with the inverse of vector bits 31:0.
- R4: The high bank changes only after a later poll in which the top two bits of the channel counter read 2'b00 (first quarter); its new value is the old high bank ANDed with the inverse of vector bits 63:32.
- R5: At the high-bank write the result is 2'b01 (ok) when the sample counter equals the value captured at the low-bank write plus one, modulo 2^SMP_W; otherwise it is 2'b10 (retry). The high bank is written in both cases.
- R6: Polls in both waiting phases together are capped at MAX_POLLS (default 1000); once the cap is reached without completion the result is 2'b11 (timeout), the high bank is not written, and a low-bank write already made stays.
- R7: A start pulse while busy is ignored: neither the captured vector nor the sequence in progress changes.
- R8: When a sequence ends busy falls and the result code holds its value until the next accepted start.
- R9: A quarter of the channel range is 2^(CH_W-2) counts, so the phase windows follow the CH_W parameter exactly at their boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one release sequence |
| clear_vec_i | input | VOICES | Voices to release, bit n = voice n |
| chan_cnt_i | input | CH_W | Running channel counter from the voice engine |
| samp_cnt_i | input | SMP_W | Running sample counter from the voice engine |
| mask_lo_o | output | VOICES/2 | Low stop-mask bank (voices 0 to 31) |
| mask_hi_o | output | VOICES/2 | High stop-mask bank (voices 32 to 63) |
| busy_o | output | 1 | Sequence in progress |
| result_o | output | 2 | 00 none, 01 ok, 10 retry, 11 timeout |

## Verification
The bench drives the phase windows at their exact edges (counts 31, 32, 47, 48, 15 and 16 for the default width); a design with an off-by-one window decode would write a bank one count early or late and diverge from the reference model at once. It forces a skipped sample boundary and a sample counter that wraps from its maximum to zero, so a design that compared without the modulo or ignored the check would report ok for the skip or retry for the wrap. It freezes the channel counter in each waiting phase long enough to hit the poll cap, catching a design that writes the high bank on timeout, counts polls per phase instead of in total, or misses the cap by one, and it fires start pulses in the middle of a sequence to catch a design that restarts.

// File: rtl/vmr_pkg.sv
package vmr_pkg;

    typedef enum logic [1:0] {
        RES_NONE    = 2'b00,
        RES_OK      = 2'b01,
        RES_RETRY   = 2'b10,
        RES_TIMEOUT = 2'b11
    } vmr_result_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_WAIT_LO = 2'b01,
        ST_WAIT_HI = 2'b10
    } vmr_state_e;

    localparam logic [1:0] QTR_FIRST = 2'b00;
    localparam logic [1:0] QTR_THIRD = 2'b10;

endpackage

// File: rtl/vmr_phase_dec.sv
module vmr_phase_dec #(
    parameter int CH_W = 6
) (
    input  logic [CH_W-1:0] chan_cnt_i,
    output logic            in_lo_win_o,
    output logic            in_hi_win_o
);
    import vmr_pkg::*;

    // The top two bits of the counter name the quarter; a quarter spans 2^(CH_W-2) counts.
    logic [1:0] quarter;

    assign quarter     = chan_cnt_i[CH_W-1 -: 2];
    assign in_lo_win_o = (quarter == QTR_THIRD);
    assign in_hi_win_o = (quarter == QTR_FIRST);

endmodule

// File: rtl/vmr_bank.sv
module vmr_bank #(
    parameter int           W       = 32,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_bits_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (clr_en_i) begin
            q_d = q_q & ~clr_bits_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= RST_VAL;
        end else begin
            q_q <= q_d;
        end
    end

    assign q_o = q_q;

endmodule

// File: rtl/vmr_poll_cnt.sv
module vmr_poll_cnt #(
    parameter int MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic expired_o
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && !expired_o) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == CW'(MAX_POLLS));

endmodule

// File: rtl/vmr_release.sv
module vmr_release #(
    parameter int                 VOICES     = 64,
    parameter int                 CH_W       = 6,
    parameter int                 SMP_W      = 6,
    parameter int                 MAX_POLLS  = 1000,
    parameter logic [VOICES-1:0]  RESET_MASK = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [VOICES-1:0]      clear_vec_i,
    input  logic [CH_W-1:0]        chan_cnt_i,
    input  logic [SMP_W-1:0]       samp_cnt_i,
    output logic [VOICES/2-1:0]    mask_lo_o,
    output logic [VOICES/2-1:0]    mask_hi_o,
    output logic                   busy_o,
    output logic [1:0]             result_o
);
    import vmr_pkg::*;

    localparam int NUM_BANKS = 2;
    localparam int BANK_W    = VOICES / NUM_BANKS;

    typedef struct packed {
        vmr_state_e        state;
        logic [VOICES-1:0] vec;
        logic [SMP_W-1:0]  sref;
        vmr_result_e       result;
    } ctl_t;

    localparam ctl_t CTL_RST = '{state: ST_IDLE, vec: '0, sref: '0, result: RES_NONE};

    ctl_t ctl_d, ctl_q;

    logic                  in_lo_win, in_hi_win;
    logic                  poll_clr, poll_inc, poll_expired;
    logic                  lo_wr, hi_wr;
    logic [NUM_BANKS-1:0]  bank_wr;
    logic [BANK_W-1:0]     bank_q [NUM_BANKS];
    logic [SMP_W-1:0]      sref_next;

    vmr_phase_dec #(.CH_W(CH_W)) u_phase (
        .chan_cnt_i (chan_cnt_i),
        .in_lo_win_o(in_lo_win),
        .in_hi_win_o(in_hi_win)
    );

    vmr_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_polls (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (poll_clr),
        .inc_i    (poll_inc),
        .expired_o(poll_expired)
    );

    assign sref_next = ctl_q.sref + SMP_W'(1);

    always_comb begin
        ctl_d    = ctl_q;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        lo_wr    = 1'b0;
        hi_wr    = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.vec    = clear_vec_i;
                    ctl_d.result = RES_NONE;
                    ctl_d.state  = ST_WAIT_LO;
                    poll_clr     = 1'b1;
                end
            end
            ST_WAIT_LO: begin
                if (poll_expired) begin
                    ctl_d.result = RES_TIMEOUT;
                    ctl_d.state  = ST_IDLE;
                end else begin
                    poll_inc = 1'b1;
                    if (in_lo_win) begin
                        lo_wr       = 1'b1;
                        ctl_d.sref  = samp_cnt_i;
                        ctl_d.state = ST_WAIT_HI;
                    end
                end
            end
            ST_WAIT_HI: begin
                if (poll_expired) begin
                    ctl_d.result = RES_TIMEOUT;
                    ctl_d.state  = ST_IDLE;
                end else begin
                    poll_inc = 1'b1;
                    if (in_hi_win) begin
                        hi_wr        = 1'b1;
                        ctl_d.result = (samp_cnt_i == sref_next) ? RES_OK : RES_RETRY;
                        ctl_d.state  = ST_IDLE;
                    end
                end
            end
            default: begin
                ctl_d = CTL_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bank_wr = {hi_wr, lo_wr};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        vmr_bank #(
            .W      (BANK_W),
            .RST_VAL(RESET_MASK[b*BANK_W +: BANK_W])
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_en_i  (bank_wr[b]),
            .clr_bits_i(ctl_q.vec[b*BANK_W +: BANK_W]),
            .q_o       (bank_q[b])
        );
    end

    assign mask_lo_o = bank_q[0];
    assign mask_hi_o = bank_q[1];
    assign busy_o    = (ctl_q.state != ST_IDLE);
    assign result_o  = ctl_q.result;

endmodule

// File: rtl/vmr_release_chk.sv
module vmr_release_chk #(
    parameter int VOICES = 64,
    parameter int CH_W   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [CH_W-1:0]     chan_cnt_i,
    input logic [VOICES/2-1:0] mask_lo_o,
    input logic [VOICES/2-1:0] mask_hi_o,
    input logic                busy_o,
    input logic [1:0]          result_o
);
    a_r3_lo_only_in_third_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mask_lo_o) |-> ($past(chan_cnt_i[CH_W-1 -: 2]) == 2'b10 && $past(busy_o)));

    a_r4_hi_only_in_first_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mask_hi_o) |-> ($past(chan_cnt_i[CH_W-1 -: 2]) == 2'b00 && $past(busy_o)));

    a_r3_banks_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_lo_o & ~$past(mask_lo_o)) == '0) && ((mask_hi_o & ~$past(mask_hi_o)) == '0));

    a_r6_timeout_leaves_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o == 2'b11 && !$stable(result_o)) |-> $stable(mask_hi_o));

    a_r2_busy_reads_none: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (result_o == 2'b00));

    a_r8_result_holds_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> (!busy_o && $stable(result_o)));

endmodule

bind vmr_release vmr_release_chk #(.VOICES(VOICES), .CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .chan_cnt_i(chan_cnt_i),
    .mask_lo_o (mask_lo_o),
    .mask_hi_o (mask_hi_o),
    .busy_o    (busy_o),
    .result_o  (result_o)
);

// File: tb/vmr_release_bench.sv
`timescale 1ns/1ps
module vmr_release_bench;
    localparam int VOICES = 64;
    localparam int HALF   = VOICES / 2;
    localparam int CH_W   = 6;
    localparam int SMP_W  = 6;
    localparam int MAXP   = 1000;
    localparam int CH_MAX = (1 << CH_W) - 1;
    localparam int SMP_M  = 1 << SMP_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [VOICES-1:0] clear_vec_i = '0;
    logic [CH_W-1:0]   chan_cnt_i = '0;
    logic [SMP_W-1:0]  samp_cnt_i = '0;
    logic [HALF-1:0]   mask_lo_o, mask_hi_o;
    logic              busy_o;
    logic [1:0]        result_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // environment counter generator controls
    bit env_run  = 1'b1;
    int env_skip = 0;

    // reference model state
    int              m_state = 0;
    int              m_polls = 0;
    logic [VOICES-1:0] m_vec = '0;
    logic [HALF-1:0] m_lo = '1;
    logic [HALF-1:0] m_hi = '1;
    int              m_ref = 0;
    int              m_res = 0;

    vmr_release #(.VOICES(VOICES), .CH_W(CH_W), .SMP_W(SMP_W), .MAX_POLLS(MAXP)) u_vmr_release (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_vec_i(clear_vec_i),
        .chan_cnt_i(chan_cnt_i), .samp_cnt_i(samp_cnt_i),
        .mask_lo_o(mask_lo_o), .mask_hi_o(mask_hi_o), .busy_o(busy_o), .result_o(result_o)
    );

    always #4 clk = ~clk;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int q;
        q = int'(chan_cnt_i) >> (CH_W - 2);
        if (!rst_n) begin
            m_state = 0; m_polls = 0; m_vec = '0; m_lo = '1; m_hi = '1; m_ref = 0; m_res = 0;
        end else if (m_state == 0) begin
            if (start_i) begin
                m_vec = clear_vec_i; m_res = 0; m_state = 1; m_polls = 0;
            end
        end else if (m_polls == MAXP) begin
            m_res = 3; m_state = 0;
        end else begin
            m_polls++;
            if (m_state == 1 && q == 2) begin
                m_lo = m_lo & ~m_vec[HALF-1:0];
                m_ref = int'(samp_cnt_i);
                m_state = 2;
            end else if (m_state == 2 && q == 0) begin
                m_hi = m_hi & ~m_vec[VOICES-1:HALF];
                m_res = (int'(samp_cnt_i) == (m_ref + 1) % SMP_M) ? 1 : 2;
                m_state = 0;
            end
        end
    endtask

    task automatic env_step();
        if (env_run) begin
            if (int'(chan_cnt_i) == CH_MAX) begin
                samp_cnt_i = samp_cnt_i + SMP_W'(1 + env_skip);
                env_skip   = 0;
            end
            chan_cnt_i = chan_cnt_i + CH_W'(1);
        end
    endtask

    // one clock: model at the edge, compare and drive at the falling edge
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R3 mask_lo", 64'(mask_lo_o), 64'(m_lo));
        check("R4 mask_hi", 64'(mask_hi_o), 64'(m_hi));
        check("R5 result",  64'(result_o),  64'(m_res));
        check("R2 busy",    64'(busy_o),    64'(m_state != 0));
        env_step();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_start(logic [VOICES-1:0] v);
        start_i = 1'b1; clear_vec_i = v;
        tick();
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy_o; i++) tick();
    endtask

    initial begin
        ticks(3);
        check("R1 reset lo", 64'(mask_lo_o), 64'(32'hFFFF_FFFF));
        check("R1 reset hi", 64'(mask_hi_o), 64'(32'hFFFF_FFFF));
        check("R1 reset result", 64'(result_o), 64'd0);
        check("R1 reset busy", 64'(busy_o), 64'd0);
        rst_n = 1'b1;
        ticks(5);

        // free running counter: normal release, expect ok
        pulse_start(64'h0000_00F0_0000_000F);
        check("R2 busy after start", 64'(busy_o), 64'd1);
        // R7: start while busy with a different vector is ignored
        pulse_start(64'hFFFF_0000_FFFF_0000);
        wait_idle();
        check("R5 ok result", 64'(result_o), 64'd1);
        check("R3 lo cleared", 64'(mask_lo_o), 64'(32'hFFFF_FFF0));
        check("R4 hi cleared", 64'(mask_hi_o), 64'(32'hFFFF_FF0F));
        check("R7 ignored vector", 64'(mask_hi_o & 32'hFFFF_0000), 64'(32'hFFFF_0000));

        // R8: result holds while idle
        ticks(20);
        check("R8 result held", 64'(result_o), 64'd1);

        // R5 retry: a skipped sample boundary between the writes
        env_skip = 1;
        pulse_start(64'h0001_0000_0001_0000);
        wait_idle();
        check("R5 retry result", 64'(result_o), 64'd2);
        check("R5 hi written on retry", 64'(mask_hi_o), 64'(32'hFFFE_FF0F));

        // R5 wrap: sample counter at maximum when the low bank is written
        env_run = 1'b0; chan_cnt_i = '0; samp_cnt_i = SMP_W'(SMP_M - 1); env_run = 1'b1;
        pulse_start(64'h0002_0000_0002_0000);
        wait_idle();
        check("R5 ok across sample wrap", 64'(result_o), 64'd1);

        // R9 window edges, counter driven by hand
        env_run = 1'b0; chan_cnt_i = CH_W'(31); samp_cnt_i = SMP_W'(10);
        pulse_start(64'h0100_0000_0100_0000);
        ticks(3);
        check("R9 count 31 not third quarter", 64'(mask_lo_o), 64'(32'hFFFC_FFF0));
        chan_cnt_i = CH_W'(48); ticks(3);
        check("R9 count 48 not third quarter", 64'(mask_lo_o), 64'(32'hFFFC_FFF0));
        chan_cnt_i = CH_W'(47); tick();
        check("R3 count 47 writes low", 64'(mask_lo_o), 64'(32'hFEFC_FFF0));
        chan_cnt_i = CH_W'(16); samp_cnt_i = SMP_W'(11); ticks(3);
        check("R9 count 16 not first quarter", 64'(mask_hi_o), 64'(32'hFFFC_FF0F));
        chan_cnt_i = CH_W'(15); tick();
        check("R4 count 15 writes high", 64'(mask_hi_o), 64'(32'hFEFC_FF0F));
        check("R5 ok by hand", 64'(result_o), 64'd1);

        // R6 timeout while waiting for the third quarter
        chan_cnt_i = CH_W'(0);
        pulse_start(64'h1000_0000_1000_0000);
        ticks(MAXP + 5);
        check("R6 timeout in low wait", 64'(result_o), 64'd3);
        check("R6 low untouched", 64'(mask_lo_o), 64'(32'hFEFC_FFF0));
        check("R6 high untouched", 64'(mask_hi_o), 64'(32'hFEFC_FF0F));

        // R6 timeout while waiting for the first quarter: low stays written
        chan_cnt_i = CH_W'(40);
        pulse_start(64'h2000_0000_2000_0000);
        ticks(MAXP + 5);
        check("R6 timeout in high wait", 64'(result_o), 64'd3);
        check("R6 low kept", 64'(mask_lo_o), 64'(32'hDEFC_FFF0));
        check("R6 high not written", 64'(mask_hi_o), 64'(32'hFEFC_FF0F));
        check("R8 idle after timeout", 64'(busy_o), 64'd0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule